// File: doc/BRIEF.md
# Three-Phase PWM Event Scheduler

This block schedules the high-side switching events of a three-phase bridge. A free-running period counter, owned by a sync generator, counts from zero to one less than a programmed period length, wraps, and produces a one-cycle sync pulse each time it starts a new period. Three compare channels watch that counter. Each channel raises its raw high-side request when the count matches its programmed turn-on value and drops it when the count matches its turn-off value. No modulation shape is built in. Symmetric PWM is obtained by writing a turn-off count equal to the period minus the turn-on count. Dead time, trip protection and the gate-level outputs belong to logic downstream of this block.

All settings arrive through a small word-wide write port. The period and the six compare values go into shadow registers. The active copies that the counter and channels use are refreshed only at a period boundary. In dual-update mode the compare values are also refreshed at mid-period. The sync generator and the channel group each have their own arming state machine with the states LOCKED, CLEARING, READY and RUNNING. Writing the clear bit moves either machine to CLEARING from any state (clear_req). Releasing the clear moves it to READY (clear_release). Setting the enable bit moves it to RUNNING (start), provided that the machine's permit input is high. Dropping the enable or the permit sends it back to READY (stop). The channel machine is permitted only while the sync generator is RUNNING.

Top module: `pwm_sched`

## Requirements
- R1: After reset all three requests and the sync output are low, and nothing runs until the control register is written.
- R2: A machine leaves LOCKED only through a clear and a release, followed by an enable. An enable written with no prior clear starts nothing. While the sync generator is not RUNNING, its counter is held at zero and no sync pulse is produced.
- R3: While the sync generator runs with a period value P ≥ 2, the sync output is high for exactly one cycle in every P cycles, and that cycle is the one in which the count is 0.
- R4: With turn-on N below turn-off F, both below P, the request of a phase is high in the cycles that follow count values N through F−1. It rises one cycle after the count shows N and falls one cycle after it shows F.
- R5: When N equals F, the request stays low for the whole period.
- R6: Clamp: with N = 0 and F ≥ P, the request stays high in every cycle.
- R7: With F below N, the request is high from count N across the wrap until count F, so the pulse straddles the period boundary.
- R8: In single-update mode, a write to the period or to a compare register during a period leaves that period unchanged. The new value takes effect from count 0 of the next period.
- R9: In dual-update mode, compare writes also take effect at the count P/2 (integer division), within the same period. The period value still changes only at a period start.
- R10: While the channel machine is not RUNNING, all requests are low. The channel machine needs its own clear/release/enable sequence, and it leaves RUNNING when the sync generator stops.
- R11: Register map on the 3-bit address. Address 0 holds the period P. Addresses 1 and 2 hold turn-on and turn-off for phase 0, addresses 3 and 4 for phase 1, addresses 5 and 6 for phase 2. Address 7 is the control register: bit0 sync clear, bit1 sync enable, bit2 channel clear, bit3 channel enable, bit4 dual-update mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| hs_req | output | 3 | Raw high-side requests, bit p for phase p |
| sync_pulse | output | 1 | One-cycle pulse at each period start |

## Verification
The bench first writes an enable with no prior clear. A design that skips the arming sequence would start counting at that point. It then writes compare and period values in the middle of a period. A design that loads shadows straight into the active copies would shift an edge or the sync spacing in the same period. Equal on/off values, the clamp and a wrapped pulse are checked after a full settling period, because an off-priority or range-check mistake would show there as a stray one-cycle pulse or a missing wrap. A compare write in dual-update mode must move an edge in the second half of the same period, which a design that never loads at mid-period fails.

// File: rtl/pwm_sched_pkg.sv
package pwm_sched_pkg;

    typedef enum logic [1:0] {
        ARM_LOCKED,
        ARM_CLEARING,
        ARM_READY,
        ARM_RUNNING
    } arm_state_t;

    localparam int CTRL_SYNC_CLR = 0;
    localparam int CTRL_SYNC_EN  = 1;
    localparam int CTRL_CH_CLR   = 2;
    localparam int CTRL_CH_EN    = 3;
    localparam int CTRL_DUAL     = 4;
    localparam int CTRL_W        = 5;

endpackage

// File: rtl/pwm_arm_fsm.sv
module pwm_arm_fsm
    import pwm_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic permit,
    output logic running
);

    arm_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ARM_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ARM_LOCKED:   if (clr) state_nx = ARM_CLEARING;
            ARM_CLEARING: if (!clr) state_nx = ARM_READY;
            ARM_READY: begin
                if (clr)                state_nx = ARM_CLEARING;
                else if (en && permit)  state_nx = ARM_RUNNING;
            end
            ARM_RUNNING: begin
                if (clr)                  state_nx = ARM_CLEARING;
                else if (!en || !permit)  state_nx = ARM_READY;
            end
            default: state_nx = ARM_LOCKED;
        endcase
    end

    always_comb running = (state == ARM_RUNNING);

    // R2: a locked machine cannot jump straight to running
    a_r2_locked_no_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARM_LOCKED) |=> (state != ARM_RUNNING));

endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             dual,
    input  logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cnt,
    output logic             sync_pulse,
    output logic             load_per,
    output logic             load_cmp
);

    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] cnt_inc;
    logic             at_end;
    logic             at_half;

    always_comb begin
        cnt_inc  = {1'b0, cnt} + EXT_W'(1);
        at_end   = (cnt_inc >= {1'b0, per_act});
        at_half  = dual && (cnt_inc == {2'b00, per_act[CNT_W-1:1]});
        load_per = !run || at_end;
        load_cmp = load_per || at_half;
        sync_pulse = run && (cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (at_end)  cnt <= '0;
        else              cnt <= cnt_inc[CNT_W-1:0];
    end

    // R2: a stopped generator holds its counter at zero
    a_r2_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    // R3: the count never reaches the period value while running
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (run && per_act != '0) |-> (cnt < per_act));

    // R3: sync lasts one cycle for periods of two or more
    a_r3_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && per_act > CNT_W'(1)) |=> !sync_pulse);

endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank #(
    parameter int CNT_W  = 16,
    parameter int PHASES = 3,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [CNT_W-1:0]             wr_data,
    input  logic                         load_per,
    input  logic                         load_cmp,
    output logic [CNT_W-1:0]             per_act,
    output logic [PHASES-1:0][CNT_W-1:0] on_act,
    output logic [PHASES-1:0][CNT_W-1:0] off_act
);

    logic [CNT_W-1:0] per_shd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_shd <= '0;
            per_act <= '0;
        end else begin
            if (wr_en && wr_addr == '0) per_shd <= wr_data;
            if (load_per)               per_act <= per_shd;
        end
    end

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        localparam logic [ADDR_W-1:0] ON_ADDR  = ADDR_W'(2 * p + 1);
        localparam logic [ADDR_W-1:0] OFF_ADDR = ADDR_W'(2 * p + 2);
        logic [CNT_W-1:0] on_shd, off_shd;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                on_shd     <= '0;
                off_shd    <= '0;
                on_act[p]  <= '0;
                off_act[p] <= '0;
            end else begin
                if (wr_en && wr_addr == ON_ADDR)  on_shd  <= wr_data;
                if (wr_en && wr_addr == OFF_ADDR) off_shd <= wr_data;
                if (load_cmp) begin
                    on_act[p]  <= on_shd;
                    off_act[p] <= off_shd;
                end
            end
        end

        // R8: active compare values only move on a load strobe
        a_r8_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
            !load_cmp |=> ($stable(on_act[p]) && $stable(off_act[p])));
    end

endmodule

// File: rtl/pwm_phase_chan.sv
module pwm_phase_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] ton,
    input  logic [CNT_W-1:0] toff,
    output logic             hs
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            hs <= 1'b0;
        else if (!run)         hs <= 1'b0;
        else if (cnt == toff)  hs <= 1'b0;
        else if (cnt == ton)   hs <= 1'b1;
    end

    // R10: a stopped channel group drives no request
    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !hs);

    // R5: equal on/off never turns a low request on
    a_r5_equal_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ton == toff && !hs) |=> !hs);

endmodule

// File: rtl/pwm_sched.sv
module pwm_sched
    import pwm_sched_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PHASES = 3,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [PHASES-1:0] hs_req,
    output logic              sync_pulse
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * PHASES + 1);

    logic [CTRL_W-1:0]             ctrl;
    logic                          sync_run, ch_run;
    logic                          load_per, load_cmp;
    logic [CNT_W-1:0]              cnt, per_act;
    logic [PHASES-1:0][CNT_W-1:0]  on_act, off_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ctrl <= '0;
        else if (wr_en && wr_addr == CTRL_ADDR) ctrl <= wr_data[CTRL_W-1:0];
    end

    pwm_arm_fsm u_sync_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctrl[CTRL_SYNC_CLR]),
        .en      (ctrl[CTRL_SYNC_EN]),
        .permit  (1'b1),
        .running (sync_run)
    );

    pwm_arm_fsm u_chan_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctrl[CTRL_CH_CLR]),
        .en      (ctrl[CTRL_CH_EN]),
        .permit  (sync_run),
        .running (ch_run)
    );

    pwm_period_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (sync_run),
        .dual       (ctrl[CTRL_DUAL]),
        .per_act    (per_act),
        .cnt        (cnt),
        .sync_pulse (sync_pulse),
        .load_per   (load_per),
        .load_cmp   (load_cmp)
    );

    pwm_shadow_bank #(.CNT_W(CNT_W), .PHASES(PHASES), .ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load_per (load_per),
        .load_cmp (load_cmp),
        .per_act  (per_act),
        .on_act   (on_act),
        .off_act  (off_act)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_chan
        pwm_phase_chan #(.CNT_W(CNT_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (ch_run),
            .cnt   (cnt),
            .ton   (on_act[p]),
            .toff  (off_act[p]),
            .hs    (hs_req[p])
        );
    end

    // R10: channels never run without the sync generator
    a_r10_chan_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_run |=> !ch_run);

endmodule

// File: tb/pwm_sched_test.sv
`timescale 1ns/1ps
module pwm_sched_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  hs_req;
    logic        sync_pulse;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int e_on [3];
    int e_off[3];
    int n_on [3];
    int n_off[3];
    int e_max;
    bit dual_mode = 0;

    always #2.5 clk = ~clk;

    pwm_sched uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hs_req(hs_req), .sync_pulse(sync_pulse)
    );

    function automatic bit exp_hs(int x, int on, int off);
        if (on == off) return 1'b0;
        if (on < off)  return (x >= on) && (x < off);
        return (x >= on) || (x < off);
    endfunction

    task automatic check(string tag, int got, int expv);
        total++;
        if (got != expv) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    task automatic note_write(int a, int d);
        if (a == 0) e_max = e_max;
        else if (a <= 6) begin
            if (a % 2 == 1) n_on[(a - 1) / 2] = d;
            else            n_off[(a - 2) / 2] = d;
        end
    endtask

    task automatic write_reg(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
        note_write(a, d);
    endtask

    task automatic wait_sync();
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (sync_pulse) return;
        end
    endtask

    task automatic commit();
        for (int p = 0; p < 3; p++) begin
            e_on[p] = n_on[p];
            e_off[p] = n_off[p];
        end
    endtask

    // Caller is positioned at a negedge where sync is high (count 0).
    task automatic check_period(string tag, int wk, int wa, int wd, int new_max);
        int mism[3];
        int got_x[3];
        int exp_x[3];
        int sync_bad = 0;
        for (int p = 0; p < 3; p++) mism[p] = 0;
        for (int k = 1; k <= e_max; k++) begin
            @(negedge clk);
            if (k == wk) begin
                wr_en = 1'b1; wr_addr = 3'(wa); wr_data = 16'(wd);
                note_write(wa, wd);
            end else begin
                wr_en = 1'b0;
            end
            for (int p = 0; p < 3; p++) begin
                int x = k - 1;
                bit use_new = dual_mode && (x >= e_max / 2) && (k - 1 > wk) && (wk > 0);
                bit ev = use_new ? exp_hs(x, n_on[p], n_off[p]) : exp_hs(x, e_on[p], e_off[p]);
                if (hs_req[p] !== ev && mism[p] == 0) begin
                    mism[p] = 1; got_x[p] = hs_req[p]; exp_x[p] = ev;
                    $display("  phase %0d first mismatch at count %0d", p, x);
                end
            end
            if (sync_pulse !== (k == e_max)) sync_bad++;
        end
        wr_en = 1'b0;
        for (int p = 0; p < 3; p++)
            check($sformatf("%s phase %0d", tag, p), mism[p] ? got_x[p] : 0, mism[p] ? exp_x[p] : 0);
        check($sformatf("%s R3 sync placement", tag), sync_bad, 0);
        commit();
        if (new_max > 0) e_max = new_max;
    endtask

    task automatic count_window(string tag, int cycles, int exp_sync, bit expect_hs_low);
        int syncs = 0;
        int hs_hi = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sync_pulse) syncs++;
            if (hs_req != 0) hs_hi++;
        end
        if (exp_sync >= 0) check($sformatf("%s sync count", tag), syncs, exp_sync);
        if (expect_hs_low) check($sformatf("%s requests low", tag), hs_hi, 0);
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        check("R1 reset requests", int'(hs_req), 0);
        check("R1 reset sync", int'(sync_pulse), 0);
    endtask

    // R11 register map, R2 enable without clear
    task automatic t_program_and_no_clear();
        e_max = 40;
        write_reg(0, 40);
        write_reg(1, 10); write_reg(2, 30);
        write_reg(3, 0);  write_reg(4, 40);
        write_reg(5, 30); write_reg(6, 8);
        commit();
        write_reg(7, 32'h02);
        count_window("R2 enable without clear", 100, 0, 1);
    endtask

    // R2, R3, R10: sync runs, channels stay idle
    task automatic t_sync_start();
        write_reg(7, 32'h01);
        write_reg(7, 32'h00);
        write_reg(7, 32'h02);
        wait_sync();
        count_window("R3 spacing P=40", 120, 3, 1);
        write_reg(7, 32'h0A);
        count_window("R10 channel enable without its clear", 100, -1, 1);
        write_reg(7, 32'h06);
        write_reg(7, 32'h02);
        write_reg(7, 32'h0A);
        wait_sync();
        wait_sync();
    endtask

    task automatic t_edges();
        check_period("R4 R6 R7 baseline", 0, 0, 0, 0);
    endtask

    // R8: mid-period compare write waits for next period
    task automatic t_single_compare();
        check_period("R8 old compare kept", 5, 1, 15, 0);
        check_period("R8 new compare active", 0, 0, 0, 0);
    endtask

    // R8: period change waits for next period
    task automatic t_single_period();
        check_period("R8 old period kept", 5, 0, 50, 50);
        check_period("R8 R3 new period 50", 0, 0, 0, 0);
    endtask

    // R6 clamp, R5 equal
    task automatic t_clamp_equal();
        check_period("R6 clamp written", 5, 4, 60, 0);
        check_period("R6 clamp on", 5, 5, 8, 0);
        repeat (e_max) @(negedge clk);
        check_period("R5 equal stays off", 0, 0, 0, 0);
    endtask

    // R9 dual update
    task automatic t_dual();
        write_reg(7, 32'h1A);
        dual_mode = 1;
        wait_sync();
        check_period("R9 dual mid-period load", 5, 2, 40, 0);
        check_period("R9 dual settled", 0, 0, 0, 0);
        dual_mode = 0;
    endtask

    // R10, R2 stop paths
    task automatic t_stop();
        write_reg(7, 32'h02);
        repeat (3) @(negedge clk);
        count_window("R10 channel stop", 100, 2, 1);
        write_reg(7, 32'h00);
        repeat (2) @(negedge clk);
        count_window("R2 sync stop", 100, 0, 1);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program_and_no_clear();
        t_sync_start();
        t_edges();
        t_single_compare();
        t_single_period();
        t_clamp_equal();
        t_dual();
        t_stop();
        finish_up();
    end

endmodule